// File: doc/BRIEF.md
# ADC Gain and Offset Corrector

This block trims the 12-bit code of an on-chip converter with a gain and an offset correction held in a 32-bit fuse word, and also scales the corrected code to millivolts. The fuse word holds three fields: a calibration-enable bit, a 10-bit gain field and a 10-bit offset field. Each field's position in the word is chosen by its own input. A load strobe copies the fields into trim registers, which keep their values until the next load. Both trims are stored with the bias of 512 removed, so each is a signed number.

A sample is offered with a valid strobe. While calibration is on, the block computes 4096 × (raw − offset trim) / (4096 + gain trim) with a restoring divider that resolves one quotient bit per clock. The result is clamped to the 12-bit code range. It is then scaled by 1500/4096 to give millivolts. While calibration is off, the raw code passes through unchanged. Every sample takes the same number of cycles. A busy output tells the producer when offered samples will be dropped.

Top module: `adc_trim_corrector`

## Requirements
- R1: When `fuse_load` is high at a clock edge, the trims are captured from `fuse_word`. The enable bit is at bit `en_pos`. The gain field is the 10 bits starting at bit `gain_pos`, and the offset field is the 10 bits starting at bit `off_pos`, both LSB first. Any field bit above bit 31 reads as 0. Later changes to `fuse_word` without a load have no effect on results.
- R2: If the captured enable bit is 1, the gain trim is the gain field minus 512 and the offset trim is the offset field minus 512.
- R3: If the captured enable bit is 0, both trims are 0. A calibrated result then equals the raw code.
- R4: With `cal_en` = 1, `code_out` = floor(4096 × (raw − offset trim) / (4096 + gain trim)).
- R5: A negative numerator (raw below the offset trim) gives `code_out` = 0.
- R6: A quotient above 4095 gives `code_out` = 4095.
- R7: With `cal_en` = 0 at acceptance, `code_out` equals the raw code, whatever the trims are.
- R8: `mv_out` = floor(`code_out` × 1500 / 4096). Its value never exceeds 1499.
- R9: A sample is accepted at a clock edge where `raw_valid` = 1 and `busy` = 0. `done` is high for exactly one cycle, 26 clock edges after the acceptance edge. `code_out` and `mv_out` change only together with `done`.
- R10: `busy` is high from the edge after acceptance until the edge that raises `done`. A `raw_valid` while `busy` is high is ignored and produces no result.
- R11: After reset, `busy`, `done`, `code_out` and `mv_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fuse_word | input | 32 | Fuse word that holds the trim fields |
| en_pos | input | 5 | Bit position of the enable bit |
| gain_pos | input | 5 | LSB position of the gain field |
| off_pos | input | 5 | LSB position of the offset field |
| fuse_load | input | 1 | Captures the trims from the fuse word |
| cal_en | input | 1 | 1 applies the trims, 0 passes the raw code through |
| raw_valid | input | 1 | Offers a raw sample |
| raw_code | input | 12 | Raw unsigned converter code |
| busy | output | 1 | A conversion is in progress; offered samples are dropped |
| done | output | 1 | One-cycle pulse when the outputs are updated |
| code_out | output | 12 | Corrected code |
| mv_out | output | 11 | Corrected value in millivolts |

## Verification
The bound checker checks timing and framing on every cycle. It checks the fixed 26-edge latency from acceptance to `done`, that `done` lasts one cycle and never overlaps `busy`, that `busy` rises after each acceptance, and that the outputs change only with `done`. On every result it also checks that a bypassed sample returns its raw code and that the millivolt value stays within range. The arithmetic itself can only be shown by the bench's scenarios. These are: trims at several bit positions, the enable bit cleared, the negative-numerator and over-range clamps, trims that keep their values when the fuse word changes without a load, and a sample offered while busy that must produce nothing.

// File: rtl/adc_trim_pkg.sv
// Shared constants for the ADC gain/offset corrector.
// Assumes a 12-bit converter, 10-bit fuse trim fields and a 32-bit fuse word.
package adc_trim_pkg;
    localparam int RAW_W   = 12;
    localparam int FIELD_W = 10;
    localparam int FUSE_W  = 32;
    localparam int MV_FULL = 1500;
endpackage

// File: rtl/adc_trim_fuse.sv
// Extracts the enable bit and the two trim fields from the fuse word.
// Stores the unbiased signed trims on a load strobe.
// Assumes the field positions are stable while load is high.
module adc_trim_fuse #(
    parameter int FUSE_W  = 32,
    parameter int FIELD_W = 10,
    localparam int POS_W  = $clog2(FUSE_W),
    localparam int TRIM_W = FIELD_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [FUSE_W-1:0]        fuse_word,
    input  logic [POS_W-1:0]         en_pos,
    input  logic [POS_W-1:0]         gain_pos,
    input  logic [POS_W-1:0]         off_pos,
    output logic signed [TRIM_W-1:0] gain_trim,
    output logic signed [TRIM_W-1:0] off_trim
);
    localparam logic [TRIM_W-1:0] BIAS = TRIM_W'(1) << (FIELD_W - 1);

    logic               en_bit;
    logic [FIELD_W-1:0] gain_fld, off_fld;
    logic signed [TRIM_W-1:0] gain_s, off_s;

    // Pick the fields out of the word and remove the bias.
    always_comb begin
        en_bit   = fuse_word[en_pos];
        gain_fld = FIELD_W'(fuse_word >> gain_pos);
        off_fld  = FIELD_W'(fuse_word >> off_pos);
        gain_s   = $signed({1'b0, gain_fld}) - $signed(BIAS);
        off_s    = $signed({1'b0, off_fld}) - $signed(BIAS);
    end

    // Capture the trims on load; a cleared enable bit gives zero trims.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain_trim <= '0;
            off_trim  <= '0;
        end else if (load) begin
            gain_trim <= en_bit ? gain_s : '0;
            off_trim  <= en_bit ? off_s  : '0;
        end
    end
endmodule

// File: rtl/adc_trim_divider.sv
// Restoring unsigned divider that resolves one quotient bit per clock.
// Takes NUM_W steps after start; fin pulses for one cycle when quo is final.
// Assumes den is nonzero and start arrives only while neither busy nor fin is high.
module adc_trim_divider #(
    parameter int NUM_W = 25,
    parameter int DEN_W = 13,
    localparam int CNT_W = $clog2(NUM_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             busy,
    output logic             fin,
    output logic [NUM_W-1:0] quo
);
    logic [DEN_W-1:0] rem_q, den_q, rem_nx;
    logic [DEN_W:0]   rem_sh;
    logic [CNT_W-1:0] cnt_q;
    logic             fits;

    // One restoring step: shift in the next numerator bit, then try to subtract.
    always_comb begin
        rem_sh = {rem_q, quo[NUM_W-1]};
        fits   = rem_sh >= {1'b0, den_q};
        rem_nx = fits ? DEN_W'(rem_sh - {1'b0, den_q}) : rem_sh[DEN_W-1:0];
    end

    // Step sequencing, quotient shift register and finish pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo   <= '0;
            rem_q <= '0;
            den_q <= '0;
            cnt_q <= '0;
            busy  <= 1'b0;
            fin   <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (start && !busy) begin
                quo   <= num;
                rem_q <= '0;
                den_q <= den;
                cnt_q <= CNT_W'(NUM_W);
                busy  <= 1'b1;
            end else if (busy) begin
                rem_q <= rem_nx;
                quo   <= {quo[NUM_W-2:0], fits};
                cnt_q <= cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) begin
                    busy <= 1'b0;
                    fin  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/adc_trim_scale.sv
// Clamps the quotient to the code range, scales it to millivolts and
// registers both outputs with a one-cycle done pulse.
// Assumes fin is a single-cycle pulse and neg is valid while fin is high.
module adc_trim_scale #(
    parameter int NUM_W   = 25,
    parameter int RAW_W   = 12,
    parameter int MV_FULL = 1500,
    localparam int MV_W   = $clog2(MV_FULL + 1),
    localparam int PROD_W = RAW_W + MV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fin,
    input  logic             neg,
    input  logic [NUM_W-1:0] quo,
    output logic             done,
    output logic [RAW_W-1:0] code_out,
    output logic [MV_W-1:0]  mv_out
);
    logic [RAW_W-1:0]  code_c;
    logic [PROD_W-1:0] prod;
    logic [MV_W-1:0]   mv_c;

    // Clamp to [0, 2^RAW_W-1] and convert to millivolts with truncation.
    always_comb begin
        if (neg)
            code_c = '0;
        else if (|quo[NUM_W-1:RAW_W])
            code_c = '1;
        else
            code_c = quo[RAW_W-1:0];
        prod = PROD_W'(code_c) * PROD_W'(MV_FULL);
        mv_c = MV_W'(prod >> RAW_W);
    end

    // Output registers, updated only when a division finishes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            code_out <= '0;
            mv_out   <= '0;
        end else begin
            done <= fin;
            if (fin) begin
                code_out <= code_c;
                mv_out   <= mv_c;
            end
        end
    end
endmodule

// File: rtl/adc_trim_corrector.sv
// Top level of the ADC gain/offset corrector.
// Accepts one sample at a time and forms the trimmed numerator and
// denominator. It runs the serial divider and then scales the result.
// Assumes fuse_load is not raised in the same cycle as an accepted sample.
module adc_trim_corrector
    import adc_trim_pkg::*;
#(
    parameter int RAW_W    = adc_trim_pkg::RAW_W,
    parameter int FIELD_W  = adc_trim_pkg::FIELD_W,
    parameter int FUSE_W   = adc_trim_pkg::FUSE_W,
    parameter int MV_FULL  = adc_trim_pkg::MV_FULL,
    localparam int POS_W   = $clog2(FUSE_W),
    localparam int TRIM_W  = FIELD_W + 1,
    localparam int DIFF_W  = RAW_W + 1,
    localparam int NUM_W   = DIFF_W + RAW_W,
    localparam int DEN_W   = RAW_W + 1,
    localparam int MV_W    = $clog2(MV_FULL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FUSE_W-1:0] fuse_word,
    input  logic [POS_W-1:0]  en_pos,
    input  logic [POS_W-1:0]  gain_pos,
    input  logic [POS_W-1:0]  off_pos,
    input  logic              fuse_load,
    input  logic              cal_en,
    input  logic              raw_valid,
    input  logic [RAW_W-1:0]  raw_code,
    output logic              busy,
    output logic              done,
    output logic [RAW_W-1:0]  code_out,
    output logic [MV_W-1:0]   mv_out
);
    logic signed [TRIM_W-1:0] gain_trim, off_trim, gain_use, off_use;
    logic signed [DIFF_W:0]   diff_s;
    logic [NUM_W-1:0]         num;
    logic [DEN_W-1:0]         den;
    logic [NUM_W-1:0]         quo;
    logic                     div_busy, div_fin, accept, neg_q;

    adc_trim_fuse #(.FUSE_W(FUSE_W), .FIELD_W(FIELD_W)) u_fuse (
        .clk(clk), .rst_n(rst_n), .load(fuse_load), .fuse_word(fuse_word),
        .en_pos(en_pos), .gain_pos(gain_pos), .off_pos(off_pos),
        .gain_trim(gain_trim), .off_trim(off_trim)
    );

    // Acceptance gate and numerator/denominator formation; bypass uses zero trims.
    always_comb begin
        busy     = div_busy | div_fin;
        accept   = raw_valid & ~busy;
        gain_use = cal_en ? gain_trim : '0;
        off_use  = cal_en ? off_trim  : '0;
        diff_s   = $signed({2'b00, raw_code})
                 - $signed({{(DIFF_W + 1 - TRIM_W){off_use[TRIM_W-1]}}, off_use});
        num      = {diff_s[DIFF_W-1:0], {RAW_W{1'b0}}};
        den      = (DEN_W'(1) << RAW_W)
                 + {{(DEN_W - TRIM_W){gain_use[TRIM_W-1]}}, gain_use};
    end

    // Remember whether the accepted numerator was negative.
    always_ff @(posedge clk) begin
        if (!rst_n)
            neg_q <= 1'b0;
        else if (accept)
            neg_q <= diff_s[DIFF_W];
    end

    adc_trim_divider #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
        .clk(clk), .rst_n(rst_n), .start(accept), .num(num), .den(den),
        .busy(div_busy), .fin(div_fin), .quo(quo)
    );

    adc_trim_scale #(.NUM_W(NUM_W), .RAW_W(RAW_W), .MV_FULL(MV_FULL)) u_scale (
        .clk(clk), .rst_n(rst_n), .fin(div_fin), .neg(neg_q), .quo(quo),
        .done(done), .code_out(code_out), .mv_out(mv_out)
    );
endmodule

// File: rtl/adc_trim_corrector_chk.sv
// Protocol and framing checker for adc_trim_corrector, bound to every instance.
// Keeps its own latency counter and a copy of the accepted sample.
module adc_trim_corrector_chk #(
    parameter int RAW_W   = 12,
    parameter int MV_W    = 11,
    parameter int MV_FULL = 1500,
    parameter int LATENCY = 26,
    localparam int LW     = $clog2(LATENCY + 2)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cal_en,
    input logic             raw_valid,
    input logic [RAW_W-1:0] raw_code,
    input logic             busy,
    input logic             done,
    input logic [RAW_W-1:0] code_out,
    input logic [MV_W-1:0]  mv_out
);
    logic [LW-1:0]    lat_cnt;
    logic [RAW_W-1:0] raw_q;
    logic             byp_q;
    logic             acc;

    assign acc = raw_valid && !busy;

    // Count edges since the last acceptance, saturating at all ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_cnt <= '1;
            raw_q   <= '0;
            byp_q   <= 1'b0;
        end else if (acc) begin
            lat_cnt <= '0;
            raw_q   <= raw_code;
            byp_q   <= !cal_en;
        end else if (lat_cnt != '1) begin
            lat_cnt <= lat_cnt + LW'(1);
        end
    end

    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_cnt == LW'(LATENCY)));
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code_out) |-> done);
    p_busy_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> busy);
    p_done_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && byp_q) |-> (code_out == raw_q));
    p_mv_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(mv_out) < MV_FULL));
endmodule

bind adc_trim_corrector adc_trim_corrector_chk #(
    .RAW_W(RAW_W), .MV_W(MV_W), .MV_FULL(MV_FULL), .LATENCY(NUM_W + 1)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cal_en(cal_en), .raw_valid(raw_valid),
    .raw_code(raw_code), .busy(busy), .done(done),
    .code_out(code_out), .mv_out(mv_out)
);

// File: tb/sim_adc_trim_corrector.sv
// Scoreboard bench: the driver pushes expected results computed from the
// requirements, and the monitor pops and compares them on each done pulse.
module sim_adc_trim_corrector;
    localparam int LAT = 26;

    typedef struct {
        int    code;
        int    mv;
        int    acc;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fuse_word = '0;
    logic [4:0]  en_pos = '0, gain_pos = '0, off_pos = '0;
    logic        fuse_load = 1'b0, cal_en = 1'b0, raw_valid = 1'b0;
    logic [11:0] raw_code = '0;
    logic        busy, done;
    logic [11:0] code_out;
    logic [10:0] mv_out;

    exp_t sb[$];
    int   cyc = 0, checks = 0, fails = 0, pushed = 0, popped = 0;
    int   m_gain = 0, m_off = 0;
    bit   ended = 0;

    always #4 clk = ~clk;

    adc_trim_corrector u0 (
        .clk(clk), .rst_n(rst_n), .fuse_word(fuse_word), .en_pos(en_pos),
        .gain_pos(gain_pos), .off_pos(off_pos), .fuse_load(fuse_load),
        .cal_en(cal_en), .raw_valid(raw_valid), .raw_code(raw_code),
        .busy(busy), .done(done), .code_out(code_out), .mv_out(mv_out)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string req, int act, int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    function automatic int model_code(int raw, bit cal);
        int d, q;
        if (!cal) return raw;
        d = raw - m_off;
        if (d < 0) return 0;
        q = (d * 4096) / (4096 + m_gain);
        return (q > 4095) ? 4095 : q;
    endfunction

    // R1 R2 R3: load the fuse word and compute the bench's own trims.
    task automatic load(logic [31:0] fw, int pe, int pg, int po);
        @(negedge clk);
        fuse_word = fw; en_pos = 5'(pe); gain_pos = 5'(pg); off_pos = 5'(po);
        fuse_load = 1'b1;
        @(negedge clk);
        fuse_load = 1'b0;
        if (((fw >> pe) & 32'h1) != 0) begin
            m_gain = int'((fw >> pg) & 32'h3FF) - 512;
            m_off  = int'((fw >> po) & 32'h3FF) - 512;
        end else begin
            m_gain = 0;
            m_off  = 0;
        end
    endtask

    // Driver: wait for a free slot, offer one sample, push its expected result.
    task automatic send(int raw, bit cal, string tag);
        exp_t e;
        @(negedge clk);
        while (busy) @(negedge clk);
        raw_code = 12'(raw); cal_en = cal; raw_valid = 1'b1;
        @(negedge clk);
        raw_valid = 1'b0;
        e.code = model_code(raw, cal);
        e.mv   = (e.code * 1500) / 4096;
        e.acc  = cyc;
        e.tag  = tag;
        sb.push_back(e);
        pushed++;
    endtask

    // Monitor: compare every done pulse against the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R10 unexpected result", int'(code_out), -1);
            end else begin
                exp_t e;
                e = sb.pop_front();
                popped++;
                check(int'(code_out) == e.code, {e.tag, " code"}, int'(code_out), e.code);
                check(int'(mv_out) == e.mv, "R8 millivolts", int'(mv_out), e.mv);
                check(cyc - e.acc == LAT, "R9 latency", cyc - e.acc, LAT);
            end
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", cyc, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(busy == 1'b0, "R11 busy", int'(busy), 0);
        check(done == 1'b0, "R11 done", int'(done), 0);
        check(code_out == '0, "R11 code", int'(code_out), 0);
        check(mv_out == '0, "R11 mv", int'(mv_out), 0);

        // R3: enable bit cleared, fields nonzero -> identity
        load(32'h0003_FFFE, 0, 2, 16);
        send(1234, 1'b1, "R3 enable off");
        send(4095, 1'b1, "R3 full scale");

        // R2 R4: enable at bit 0, gain 600 at bit 2, offset 530 at bit 16
        load(32'h1 | (32'd600 << 2) | (32'd530 << 16), 0, 2, 16);
        send(1000, 1'b1, "R4 mid code");
        send(4095, 1'b1, "R4 top code");
        send(18, 1'b1, "R4 equal to offset");
        send(0, 1'b1, "R5 negative numerator");
        send(17, 1'b1, "R5 just below offset");

        // R7: bypass ignores active trims
        send(3000, 1'b0, "R7 bypass");

        // R1: fuse word changes without a load -> old trims still used
        @(negedge clk);
        fuse_word = 32'h0;
        send(2500, 1'b1, "R1 held trims");

        // R6: gain -512, offset -512, enable at bit 31
        load(32'h8000_0000, 31, 4, 20);
        send(4095, 1'b1, "R6 clamp high");
        send(100, 1'b1, "R4 low gain");

        // R1: gain field runs past bit 31 (upper field bits read as 0)
        load(32'hFE00_0001, 0, 25, 1);
        send(2048, 1'b1, "R1 field past top");

        // R10: a sample offered while busy is dropped
        send(1500, 1'b1, "R10 first sample");
        repeat (3) @(negedge clk);
        check(busy == 1'b1, "R10 busy during run", int'(busy), 1);
        raw_code = 12'd77; cal_en = 1'b0; raw_valid = 1'b1;
        @(negedge clk);
        raw_valid = 1'b0;
        send(3333, 1'b0, "R10 next after busy");

        while (sb.size() != 0) @(negedge clk);
        repeat (40) @(negedge clk);
        check(popped == pushed, "R10 result count", popped, pushed);
        check(busy == 1'b0 && done == 1'b0, "R9 idle at end", int'(busy), 0);
        finish_run();
    end
endmodule